// File: doc/BRIEF.md
# Sector Hamming Code Generator and Checker

This block computes a single-error-correcting, double-error-detecting Hamming code over one sector of bytes while the bytes stream through. Every data bit in the sector has a 12-bit location: its byte offset in the upper nine bits and its bit position inside the byte in the lower three. For each location bit there are two parities. The "set" parity covers all data bits whose location has that bit at one. The "clear" parity covers all data bits whose location has it at zero. The set parities form the upper 12-bit group of the code and the clear parities form the lower group. The block inverts the 24-bit code before it is presented, so a sector of all ones (an erased sector) produces the code 0xFFFFFF. That is also the code an erased spare area holds.

Writing a sector works like this. The host pulses `sec_start` with the first byte and streams the sector with `byte_valid`. It then stores `code_out` as three bytes, low byte first. Reading a sector works the same way until the code is ready. The host then presents the stored code on `chk_code` with `chk_valid`. The block XORs the stored code with the freshly computed one and classifies the difference. It reports a clean sector, a correctable data bit with its byte offset and bit index, a fault in the stored code alone, or an uncorrectable sector. The block does not repair the data buffer itself.

Top module: `hamming_sector_ecc`

## Requirements
- R1: After reset, `code_out` is all ones, and `code_done` and `res_valid` are low.
- R2: After `sec_start` and SECTOR_BYTES accepted bytes, `code_out` equals the inverse of {set group, clear group}. Bit 12+k is the inverted XOR of data bits whose location {offset[8:0], bit[2:0]} has bit k set. Bit k is the inverted XOR of those whose location has bit k clear. Byte 0 of the stored form is `code_out[7:0]`.
- R3: A sector of all 0xFF bytes yields `code_out` = 0xFFFFFF.
- R4: `code_done` is high for exactly the one cycle after the edge that accepts the last byte. `code_out` changes only then. Bytes offered with no sector in progress are ignored and leave `code_out` unchanged.
- R5: A `sec_start` in the middle of a sector discards the bytes seen so far. The byte offered in the same cycle as `sec_start` is byte 0 of the new sector.
- R6: A `chk_valid` cycle yields a one-cycle `res_valid` pulse on the next cycle, and `res_valid` is never high without a request.
- R7: When the stored code equals `code_out`, the status is 0 (clean), with offset 0 and bit 0.
- R8: When the upper 12 bits of the difference XOR its lower 12 bits equal 0xFFF and the offset is in range, the status is 1 (data bit). The offset is difference bits 23:15 and the bit index is difference bits 14:12.
- R9: A location of that form whose offset is not below SECTOR_BYTES gives status 3 (uncorrectable), with offset 0 and bit 0.
- R10: A difference with exactly one bit set gives status 2 (stored code fault), with offset 0 and bit 0.
- R11: Any other nonzero difference, such as two flipped data bits, gives status 3 with offset 0 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_start | input | 1 | Begin a new sector; a same-cycle byte is byte 0 |
| byte_valid | input | 1 | Byte offered on `byte_data` |
| byte_data | input | 8 | Sector byte |
| code_out | output | 24 | Inverted code of the last completed sector |
| code_done | output | 1 | One-cycle pulse when `code_out` is refreshed |
| chk_valid | input | 1 | Compare request |
| chk_code | input | 24 | Stored code, byte 0 in bits 7:0 |
| res_valid | output | 1 | Result pulse, one cycle after the request |
| res_status | output | 2 | 0 clean, 1 data bit, 2 code fault, 3 uncorrectable |
| res_offset | output | 9 | Byte offset of the bad bit (status 1 only) |
| res_bit | output | 3 | Bit index of the bad bit (status 1 only) |

## Verification
The out-of-range location of R9 cannot occur with a 512-byte sector, because nine offset bits never reach 512. The bench therefore adds a second instance with a 384-byte sector. After reset that instance holds the erased code, so a stored code built from the location signature of an offset at or above 384 reaches the case without streaming any data. Streaming one sector per flipped bit would take millions of cycles. The bench instead streams one random sector and then presents, for all 4096 data-bit locations, the stored code that a flip there would produce. Two-bit errors use stored codes computed from a modified sector copy.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = 3;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_DATA_FIX  = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_FATAL     = 2'd3
    } ecc_status_e;

    // Lanes of a byte whose bit position has index bit b set
    function automatic logic [BYTE_W-1:0] lane_mask(input int b);
        logic [BYTE_W-1:0] m;
        for (int j = 0; j < BYTE_W; j++) begin
            m[j] = ((j >> b) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hecc_accum.sv
module hecc_accum
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sec_start,
    input  logic                          byte_valid,
    input  logic [BYTE_W-1:0]             byte_data,
    output logic                          sector_end,
    output logic [$clog2(SECTOR_BYTES)+BIT_IDX_W-1:0] hi_fin,
    output logic [$clog2(SECTOR_BYTES)+BIT_IDX_W-1:0] lo_fin
);
    localparam int OFF_W   = $clog2(SECTOR_BYTES);
    localparam int GROUP_W = OFF_W + BIT_IDX_W;
    localparam logic [OFF_W-1:0] LAST = OFF_W'(SECTOR_BYTES - 1);

    typedef struct packed {
        logic               armed;
        logic [OFF_W-1:0]   cnt;
        logic [GROUP_W-1:0] hi;
        logic [GROUP_W-1:0] lo;
    } acc_t;

    acc_t st_q, st_d;

    logic               b_arm;
    logic [OFF_W-1:0]   b_cnt;
    logic [GROUP_W-1:0] b_hi, b_lo, c_hi, c_lo;
    logic               par, take;

    always_comb begin
        b_arm = sec_start | st_q.armed;
        b_cnt = sec_start ? '0 : st_q.cnt;
        b_hi  = sec_start ? '0 : st_q.hi;
        b_lo  = sec_start ? '0 : st_q.lo;
        take  = byte_valid & b_arm;
        par   = ^byte_data;

        for (int b = 0; b < BIT_IDX_W; b++) begin
            c_hi[b] = ^(byte_data &  lane_mask(b));
            c_lo[b] = ^(byte_data & ~lane_mask(b));
        end
        for (int m = 0; m < OFF_W; m++) begin
            c_hi[BIT_IDX_W+m] = par &  b_cnt[m];
            c_lo[BIT_IDX_W+m] = par & ~b_cnt[m];
        end

        hi_fin     = take ? (b_hi ^ c_hi) : b_hi;
        lo_fin     = take ? (b_lo ^ c_lo) : b_lo;
        sector_end = take & (b_cnt == LAST);

        st_d.armed = b_arm & ~sector_end;
        st_d.cnt   = sector_end ? '0 : b_cnt + {{(OFF_W-1){1'b0}}, take};
        st_d.hi    = sector_end ? '0 : hi_fin;
        st_d.lo    = sector_end ? '0 : lo_fin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/hecc_pack.sv
module hecc_pack #(
    parameter int GROUP_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sector_end,
    input  logic [GROUP_W-1:0]     hi_fin,
    input  logic [GROUP_W-1:0]     lo_fin,
    output logic [2*GROUP_W-1:0]   code_out,
    output logic                   code_done
);
    localparam int CODE_W = 2 * GROUP_W;

    typedef struct packed {
        logic              done;
        logic [CODE_W-1:0] code;
    } pack_t;

    pack_t st_q, st_d;

    always_comb begin
        st_d.done = sector_end;
        // inversion makes an erased sector agree with an erased spare area
        st_d.code = sector_end ? ~{hi_fin, lo_fin} : st_q.code;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.done <= 1'b0;
            st_q.code <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_out  = st_q.code;
    assign code_done = st_q.done;

endmodule

// File: rtl/hecc_correct.sv
module hecc_correct
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          chk_valid,
    input  logic [2*($clog2(SECTOR_BYTES)+BIT_IDX_W)-1:0] chk_code,
    input  logic [2*($clog2(SECTOR_BYTES)+BIT_IDX_W)-1:0] calc_code,
    output logic                                          res_valid,
    output logic [1:0]                                    res_status,
    output logic [$clog2(SECTOR_BYTES)-1:0]               res_offset,
    output logic [BIT_IDX_W-1:0]                          res_bit
);
    localparam int OFF_W   = $clog2(SECTOR_BYTES);
    localparam int GROUP_W = OFF_W + BIT_IDX_W;
    localparam int CODE_W  = 2 * GROUP_W;
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(SECTOR_BYTES);

    typedef struct packed {
        logic                 valid;
        ecc_status_e          status;
        logic [OFF_W-1:0]     off;
        logic [BIT_IDX_W-1:0] bidx;
    } res_t;

    res_t st_q, st_d;

    logic [CODE_W-1:0]    diff;
    logic [GROUP_W-1:0]   fold;
    logic [OFF_W-1:0]     loc_off;
    logic [BIT_IDX_W-1:0] loc_bit;

    always_comb begin
        diff    = chk_code ^ calc_code;
        fold    = diff[CODE_W-1:GROUP_W] ^ diff[GROUP_W-1:0];
        loc_off = diff[CODE_W-1 -: OFF_W];
        loc_bit = diff[GROUP_W +: BIT_IDX_W];

        st_d       = st_q;
        st_d.valid = chk_valid;
        if (chk_valid) begin
            st_d.off  = '0;
            st_d.bidx = '0;
            if (diff == '0) begin
                st_d.status = ST_CLEAN;
            end else if (&fold) begin
                if ({1'b0, loc_off} < LIMIT) begin
                    st_d.status = ST_DATA_FIX;
                    st_d.off    = loc_off;
                    st_d.bidx   = loc_bit;
                end else begin
                    st_d.status = ST_FATAL;
                end
            end else if ($onehot(diff)) begin
                st_d.status = ST_CODE_ONLY;
            end else begin
                st_d.status = ST_FATAL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid  <= 1'b0;
            st_q.status <= ST_CLEAN;
            st_q.off    <= '0;
            st_q.bidx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid  = st_q.valid;
    assign res_status = st_q.status;
    assign res_offset = st_q.off;
    assign res_bit    = st_q.bidx;

endmodule

// File: rtl/hamming_sector_ecc.sv
module hamming_sector_ecc
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          sec_start,
    input  logic                                          byte_valid,
    input  logic [7:0]                                    byte_data,
    output logic [2*($clog2(SECTOR_BYTES)+3)-1:0]         code_out,
    output logic                                          code_done,
    input  logic                                          chk_valid,
    input  logic [2*($clog2(SECTOR_BYTES)+3)-1:0]         chk_code,
    output logic                                          res_valid,
    output logic [1:0]                                    res_status,
    output logic [$clog2(SECTOR_BYTES)-1:0]               res_offset,
    output logic [2:0]                                    res_bit
);
    localparam int OFF_W   = $clog2(SECTOR_BYTES);
    localparam int GROUP_W = OFF_W + BIT_IDX_W;

    logic               sector_end;
    logic [GROUP_W-1:0] hi_fin, lo_fin;

    hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_start  (sec_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .sector_end (sector_end),
        .hi_fin     (hi_fin),
        .lo_fin     (lo_fin)
    );

    hecc_pack #(.GROUP_W(GROUP_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .sector_end (sector_end),
        .hi_fin     (hi_fin),
        .lo_fin     (lo_fin),
        .code_out   (code_out),
        .code_done  (code_done)
    );

    hecc_correct #(.SECTOR_BYTES(SECTOR_BYTES)) u_correct (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .chk_code   (chk_code),
        .calc_code  (code_out),
        .res_valid  (res_valid),
        .res_status (res_status),
        .res_offset (res_offset),
        .res_bit    (res_bit)
    );

endmodule

// File: rtl/hecc_checker.sv
module hecc_checker #(
    parameter int SECTOR_BYTES = 512
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [2*($clog2(SECTOR_BYTES)+3)-1:0] code_out,
    input logic                                  code_done,
    input logic                                  chk_valid,
    input logic [2*($clog2(SECTOR_BYTES)+3)-1:0] chk_code,
    input logic                                  res_valid,
    input logic [1:0]                            res_status,
    input logic [$clog2(SECTOR_BYTES)-1:0]       res_offset,
    input logic [2:0]                            res_bit
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_done |=> !code_done); // R4
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !code_done |-> $stable(code_out)); // R4
    AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid); // R6
    AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chk_valid)); // R6
    AST_CLEAN_IFF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_status == 2'd0) == ($past(chk_code) == $past(code_out)))); // R7
    AST_FIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd1) |-> (int'(res_offset) < SECTOR_BYTES)); // R9
    AST_ONE_BIT_CODE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $countones($past(chk_code ^ code_out)) == 1) |-> res_status == 2'd2); // R10
    AST_LOC_ZERO_UNLESS_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != 2'd1) |-> (res_offset == '0 && res_bit == '0)); // R11
endmodule

bind hamming_sector_ecc hecc_checker #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_out   (code_out),
    .code_done  (code_done),
    .chk_valid  (chk_valid),
    .chk_code   (chk_code),
    .res_valid  (res_valid),
    .res_status (res_status),
    .res_offset (res_offset),
    .res_bit    (res_bit)
);

// File: tb/tb_hamming_sector_ecc.sv
`timescale 1ns/1ps
module tb_hamming_sector_ecc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_start = 1'b0, byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [23:0] code_out, chk_code = '0;
    logic        code_done, chk_valid = 1'b0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [8:0]  res_offset;
    logic [2:0]  res_bit;

    // second instance with a short sector for out-of-range locations
    logic        s_chk_valid = 1'b0;
    logic [23:0] s_chk_code = '0, s_code_out;
    logic        s_code_done, s_res_valid;
    logic [1:0]  s_res_status;
    logic [8:0]  s_res_offset;
    logic [2:0]  s_res_bit;

    int n_checks = 0, n_fail = 0;
    logic [7:0] sec [512];

    always #2 clk = ~clk;

    hamming_sector_ecc #(.SECTOR_BYTES(512)) dut (
        .clk(clk), .rst_n(rst_n), .sec_start(sec_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .code_out(code_out), .code_done(code_done),
        .chk_valid(chk_valid), .chk_code(chk_code), .res_valid(res_valid),
        .res_status(res_status), .res_offset(res_offset), .res_bit(res_bit));

    hamming_sector_ecc #(.SECTOR_BYTES(384)) dut_small (
        .clk(clk), .rst_n(rst_n), .sec_start(1'b0), .byte_valid(1'b0),
        .byte_data(8'h00), .code_out(s_code_out), .code_done(s_code_done),
        .chk_valid(s_chk_valid), .chk_code(s_chk_code), .res_valid(s_res_valid),
        .res_status(s_res_status), .res_offset(s_res_offset), .res_bit(s_res_bit));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // code from the requirement text: set/clear parities per location bit, inverted
    function automatic logic [23:0] ref_code();
        logic [11:0] up = '0, lo = '0, loc;
        for (int i = 0; i < 512; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (sec[i][j]) begin
                    loc = 12'(i * 8 + j);
                    for (int k = 0; k < 12; k++) begin
                        if (loc[k]) up[k] = ~up[k];
                        else        lo[k] = ~lo[k];
                    end
                end
            end
        end
        return ~{up, lo};
    endfunction

    // effect on the code of one flipped data bit at location a
    function automatic logic [23:0] flip_sig(input logic [11:0] a);
        return {a, ~a};
    endfunction

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sec_start  = (i == 0);
            byte_valid = 1'b1;
            byte_data  = sec[i];
        end
        @(negedge clk);
        sec_start  = 1'b0;
        byte_valid = 1'b0;
    endtask

    task automatic compare(input logic [23:0] stored);
        @(negedge clk);
        chk_valid = 1'b1;
        chk_code  = stored;
        @(negedge clk);
        chk_valid = 1'b0;
    endtask

    task automatic compare_small(input logic [23:0] stored);
        @(negedge clk);
        s_chk_valid = 1'b1;
        s_chk_code  = stored;
        @(negedge clk);
        s_chk_valid = 1'b0;
    endtask

    function automatic logic [31:0] res_pack(input logic [1:0] st, input logic [8:0] off, input logic [2:0] b);
        return {18'd0, st, off, b};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] base, held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 code after reset", code_out, 24'hFFFFFF);
        check("R1 done after reset", code_done, 0);
        check("R1 res_valid after reset", res_valid, 0);
        rst_n = 1'b1;

        // erased sector
        for (int i = 0; i < 512; i++) sec[i] = 8'hFF;
        stream(512);
        check("R4 done after last byte", code_done, 1);
        check("R3 erased code", code_out, 24'hFFFFFF);
        check("R2 erased vs model", code_out, ref_code());
        @(negedge clk);
        check("R4 done single cycle", code_done, 0);
        compare(24'hFFFFFF);
        check("R7 clean result", res_pack(res_status, res_offset, res_bit), res_pack(2'd0, 9'd0, 3'd0));
        check("R6 result valid", res_valid, 1);
        @(negedge clk);
        check("R6 result one cycle", res_valid, 0);

        // mid-sector restart then a random sector
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
        stream(100);
        for (int i = 0; i < 512; i++) sec[i] = 8'($urandom);
        stream(512);
        check("R5 restart code", code_out, ref_code());
        check("R4 done after restart", code_done, 1);
        base = code_out;

        // bytes with no sector in progress
        held = code_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            byte_data  = 8'($urandom);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        check("R4 idle bytes ignored", code_out, held);
        check("R4 no done on idle bytes", code_done, 0);

        // a few more random and directed sectors
        for (int t = 0; t < 3; t++) begin
            for (int i = 0; i < 512; i++)
                sec[i] = (t == 0) ? 8'h00 : (t == 1) ? 8'(i) : 8'($urandom);
            stream(512);
            check("R2 sector code", code_out, ref_code());
        end
        base = code_out;

        // every single data bit location
        for (int a = 0; a < 4096; a++) begin
            compare(base ^ flip_sig(12'(a)));
            check("R8 single data bit", res_pack(res_status, res_offset, res_bit),
                  res_pack(2'd1, 9'(a >> 3), 3'(a)));
        end

        // fault in the stored code only
        for (int k = 0; k < 24; k++) begin
            compare(base ^ (24'd1 << k));
            check("R10 stored code bit", res_pack(res_status, res_offset, res_bit),
                  res_pack(2'd2, 9'd0, 3'd0));
        end

        // two flipped data bits
        for (int t = 0; t < 20; t++) begin
            int p, q;
            logic [23:0] st;
            p = int'($urandom % 4096);
            q = (p + 1 + int'($urandom % 4095)) % 4096;
            sec[p/8][p%8] = ~sec[p/8][p%8];
            sec[q/8][q%8] = ~sec[q/8][q%8];
            st = ref_code();
            sec[p/8][p%8] = ~sec[p/8][p%8];
            sec[q/8][q%8] = ~sec[q/8][q%8];
            compare(st);
            check("R11 two data bits", res_pack(res_status, res_offset, res_bit),
                  res_pack(2'd3, 9'd0, 3'd0));
        end
        compare(base ^ 24'h000003);
        check("R11 two code bits", res_pack(res_status, res_offset, res_bit), res_pack(2'd3, 9'd0, 3'd0));

        // short-sector instance: reset code is all ones
        check("R1 short instance code", s_code_out, 24'hFFFFFF);
        compare_small(24'hFFFFFF ^ flip_sig({9'd400, 3'd5}));
        check("R9 offset beyond sector", res_pack(s_res_status, s_res_offset, s_res_bit),
              res_pack(2'd3, 9'd0, 3'd0));
        compare_small(24'hFFFFFF ^ flip_sig({9'd384, 3'd0}));
        check("R9 offset equal sector", res_pack(s_res_status, s_res_offset, s_res_bit),
              res_pack(2'd3, 9'd0, 3'd0));
        compare_small(24'hFFFFFF ^ flip_sig({9'd383, 3'd7}));
        check("R8 last offset in short sector", res_pack(s_res_status, s_res_offset, s_res_bit),
              res_pack(2'd1, 9'd383, 3'd7));

        finish_run();
    end

endmodule